// File: doc/BRIEF.md
# Parallel Byte Loader with Ready/Busy Status

This block lets a host processor push configuration bytes into a chip over a plain parallel bus. The host selects the port with a pair of chip selects of opposite polarity, then pulses a write strobe to deposit one byte into a single-entry holding register. The held byte is offered to a downstream bit serializer over a valid/ready stream. The host can also pulse a read strobe to learn whether the holding register is free again.

All strobe and select pins are asynchronous to the block clock, so they pass through a synchronizer before any decision is taken. A byte is taken once per falling edge of the write strobe, so a strobe held low for many cycles loads one byte. The data pins form a tristate bus split into an input, an output and an output enable. During a status read the top line carries ready (high) or busy (low), and every other line sits at its inactive high level. A write that arrives while the holding register is still occupied is discarded, and a sticky error flag records it.

Downstream stream rules: `ser_valid` rises when a byte is captured and stays high, with `ser_data` unchanged, until a cycle in which `ser_ready` is also high. The byte leaves in that cycle. `ser_ready` may be held low for any length of time. Back-pressure is never lost; it turns into a busy status for the host, and then into dropped writes if the host does not check that status.

Top module: `cfg_byte_port`

## Requirements
- R1: The port acts only while its synchronized selects read `sel_lo_n`=0 and `sel_hi`=1; with any other select combination a write strobe captures nothing and `bus_oe` stays 0.
- R2: While selected, a high-to-low transition of the synchronized write strobe loads `bus_in` into the holding register, which appears on `ser_data` with `ser_valid`=1; keeping the strobe low loads nothing further.
- R3: The port is busy from a capture until the first clock in which `ser_valid` and `ser_ready` are both 1; while `ser_ready` is 0, `ser_valid` stays 1 and `ser_data` stays unchanged.
- R4: While selected, with the read strobe low and the write strobe high, `bus_oe`=1 and `bus_out` carries bit DATA_W-1 = 1 when idle or 0 when busy, with bits DATA_W-2..0 all 1 (0xFF ready, 0x7F busy for 8 bits).
- R5: When both strobes are low, the write is carried out and `bus_oe` stays 0.
- R6: A write strobe fall while busy leaves the held byte unchanged and sets `overrun` to 1, which then stays 1 until reset.
- R7: Strobe and select changes take effect after SYNC_STAGES rising clock edges; a write fall presented before edge 1 makes `ser_valid` 1 after edge SYNC_STAGES+1 and not before.
- R8: After reset, `ser_valid`=0, `bus_oe`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_lo_n | input | 1 | Chip select, active low (asynchronous) |
| sel_hi | input | 1 | Chip select, active high (asynchronous) |
| wr_strobe_n | input | 1 | Write strobe, active low (asynchronous) |
| rd_strobe_n | input | 1 | Read strobe, active low (asynchronous) |
| bus_in | input | DATA_W | Data pins, input side |
| bus_out | output | DATA_W | Data pins, output side (status word) |
| bus_oe | output | 1 | Drive enable for the data pins |
| ser_valid | output | 1 | Byte available toward the serializer |
| ser_data | output | DATA_W | Byte toward the serializer |
| ser_ready | input | 1 | Serializer accepts the byte |
| overrun | output | 1 | Sticky: a write was dropped while busy |

## Verification
The bench builds the port with DATA_W=8 and SYNC_STAGES=3. The deeper synchronizer makes the latency check distinguish the parameterized delay from a hard-wired two-stage one. The 8-bit width lets the status words 0xFF and 0x7F be checked literally. A behavioural model holds the synchronizer delay in a queue of that depth and compares every output on every clock. Randomized strobes and back-pressure then reach writes during busy, writes during handshake cycles and overlapping strobes.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef struct packed {
    logic sel_lo_n;
    logic sel_hi;
    logic wr_n;
    logic rd_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

  localparam strobe_t STROBE_IDLE = '{sel_lo_n: 1'b1, sel_hi: 1'b0, wr_n: 1'b1, rd_n: 1'b1};

  function automatic logic port_selected(input strobe_t s);
    return !s.sel_lo_n && s.sel_hi;
  endfunction

endpackage

// File: rtl/cfg_sync_chain.sv
module cfg_sync_chain #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_write_capture.sv
module cfg_write_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_n_s,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              ser_ready,
  output logic              ser_valid,
  output logic [DATA_W-1:0] ser_data,
  output logic              overrun,
  output logic              wr_event
);

  logic              wr_prev;
  logic              full_q;
  logic              ovr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_n_s;
  end

  assign wr_event = wr_prev && !wr_n_s && sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (full_q && ser_ready) full_q <= 1'b0;
      if (wr_event) begin
        if (full_q) begin
          ovr_q <= 1'b1;
        end else begin
          full_q <= 1'b1;
          data_q <= bus_in;
        end
      end
    end
  end

  assign ser_valid = full_q;
  assign ser_data  = data_q;
  assign overrun   = ovr_q;

  // R3: an offered byte waits, unchanged, for the serializer
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_data)));

  // R2: an accepted write is offered with the bus value
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_event && !ser_valid) |=> (ser_valid && ser_data == $past(bus_in)));

  // R6: a write while busy keeps the byte and flags the loss
  assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_event && ser_valid) |=> ($stable(ser_data) && overrun));

  // R6: the loss flag is sticky
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

// File: rtl/cfg_status_drive.sv
module cfg_status_drive #(
  parameter int DATA_W = 8
) (
  input  logic              sel,
  input  logic              wr_n_s,
  input  logic              rd_n_s,
  input  logic              busy,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_out
);

  localparam int LOW_W = DATA_W - 1;

  always_comb begin
    bus_oe  = sel && !rd_n_s && wr_n_s;
    bus_out = {!busy, {LOW_W{1'b1}}};
  end

endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lo_n,
  input  logic              sel_hi,
  input  logic              wr_strobe_n,
  input  logic              rd_strobe_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              ser_valid,
  output logic [DATA_W-1:0] ser_data,
  input  logic              ser_ready,
  output logic              overrun
);

  import cfg_port_pkg::*;

  strobe_t raw_s;
  strobe_t sync_s;
  logic    sel_s;
  logic    wr_event;

  assign raw_s = '{sel_lo_n: sel_lo_n, sel_hi: sel_hi, wr_n: wr_strobe_n, rd_n: rd_strobe_n};

  cfg_sync_chain #(
    .W      (STROBE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(STROBE_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_s),
    .q    (sync_s)
  );

  assign sel_s = port_selected(sync_s);

  cfg_write_capture #(
    .DATA_W(DATA_W)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel_s),
    .wr_n_s   (sync_s.wr_n),
    .bus_in   (bus_in),
    .ser_ready(ser_ready),
    .ser_valid(ser_valid),
    .ser_data (ser_data),
    .overrun  (overrun),
    .wr_event (wr_event)
  );

  cfg_status_drive #(
    .DATA_W(DATA_W)
  ) u_status (
    .sel    (sel_s),
    .wr_n_s (sync_s.wr_n),
    .rd_n_s (sync_s.rd_n),
    .busy   (ser_valid),
    .bus_oe (bus_oe),
    .bus_out(bus_out)
  );

  // R1: nothing is driven while the port is not selected
  assert_unselected_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |-> !bus_oe);

  // R5: a write in progress never drives the bus
  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |-> !bus_oe);

  // R4: the status bit mirrors the holding register
  assert_status_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_out[DATA_W-1] == !ser_valid));

  initial begin
    assert_params_R7: assert (SYNC_STAGES >= 1 && DATA_W >= 2);
  end

endmodule

// File: tb/cfg_byte_port_tb_top.sv
module cfg_byte_port_tb_top;

  localparam int DW = 8;
  localparam int SS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_lo_n = 1'b1, sel_hi = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out;
  logic          bus_oe;
  logic          ser_valid;
  logic [DW-1:0] ser_data;
  logic          ser_ready = 1'b0;
  logic          overrun;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_byte_port #(.DATA_W(DW), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
    .wr_strobe_n(wr_n), .rd_strobe_n(rd_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ser_valid(ser_valid),
    .ser_data(ser_data), .ser_ready(ser_ready), .overrun(overrun));

  // behavioural reference
  typedef struct {bit lo_n; bit hi; bit wr; bit rd;} smp_t;
  smp_t    q[$];
  bit      m_wrd, m_full, m_ovr;
  bit [7:0] m_data;

  task automatic model_reset();
    smp_t idle;
    idle = '{lo_n: 1, hi: 0, wr: 1, rd: 1};
    q = {};
    for (int i = 0; i < SS; i++) q.push_back(idle);
    m_wrd = 1; m_full = 0; m_ovr = 0; m_data = '0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      smp_t s, cur;
      bit old_full;
      s = q[0];
      old_full = m_full;
      if (m_full && ser_ready) m_full = 0;
      if (m_wrd && !s.wr && !s.lo_n && s.hi) begin
        if (old_full) m_ovr = 1;
        else begin m_full = 1; m_data = bus_in; end
      end
      m_wrd = s.wr;
      cur = '{lo_n: sel_lo_n, hi: sel_hi, wr: wr_n, rd: rd_n};
      q.push_back(cur);
      void'(q.pop_front());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      smp_t s;
      bit exp_oe;
      s = q[0];
      exp_oe = !s.lo_n && s.hi && !s.rd && s.wr;
      check(ser_valid == m_full, "R3 ser_valid", ser_valid, m_full);
      if (m_full) check(ser_data == m_data, "R2 ser_data", ser_data, m_data);
      check(bus_oe == exp_oe, "R4 bus_oe", bus_oe, exp_oe);
      if (exp_oe) check(bus_out == {!m_full, 7'h7F}, "R4 bus_out", bus_out, {!m_full, 7'h7F});
      check(overrun == m_ovr, "R6 overrun", overrun, m_ovr);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input bit lo, input bit hi, input bit w, input bit r, input logic [7:0] d);
    sel_lo_n = lo; sel_hi = hi; wr_n = w; rd_n = r; bus_in = d;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R8: reset state
    check(ser_valid == 0, "R8 valid after reset", ser_valid, 0);
    check(bus_oe == 0, "R8 oe after reset", bus_oe, 0);
    check(overrun == 0, "R8 overrun after reset", overrun, 0);

    // R4: idle status read
    pins(0, 1, 1, 0, 8'h00); cyc(SS + 1);
    check(bus_oe == 1, "R4 oe on read", bus_oe, 1);
    check(bus_out == 8'hFF, "R4 ready word", bus_out, 8'hFF);
    pins(0, 1, 1, 1, 8'h00); cyc(SS + 1);

    // R7: latency of a write
    pins(0, 1, 0, 1, 8'hA5);
    cyc(SS);
    check(ser_valid == 0, "R7 not yet valid", ser_valid, 0);
    cyc(1);
    check(ser_valid == 1, "R7 valid after SS+1", ser_valid, 1);
    check(ser_data == 8'hA5, "R2 captured byte", ser_data, 8'hA5);
    // R2/R3: strobe held low, no recapture, byte held
    bus_in = 8'h42; cyc(6);
    check(ser_data == 8'hA5, "R2 single capture", ser_data, 8'hA5);
    check(overrun == 0, "R2 no second capture", overrun, 0);
    check(ser_valid == 1, "R3 held under back-pressure", ser_valid, 1);
    // R4: busy status
    pins(0, 1, 1, 0, 8'h00); cyc(SS + 1);
    check(bus_out == 8'h7F, "R4 busy word", bus_out, 8'h7F);
    pins(0, 1, 1, 1, 8'h00); cyc(SS + 1);

    // R6: write while busy
    pins(0, 1, 0, 1, 8'h3C); cyc(SS + 2);
    check(ser_data == 8'hA5, "R6 byte kept", ser_data, 8'hA5);
    check(overrun == 1, "R6 overrun set", overrun, 1);
    pins(0, 1, 1, 1, 8'h00); cyc(SS + 1);

    // R3: handshake releases
    ser_ready = 1; cyc(1);
    check(ser_valid == 0, "R3 released on handshake", ser_valid, 0);
    ser_ready = 0; cyc(1);

    // R1: wrong select levels
    pins(1, 1, 0, 1, 8'h11); cyc(SS + 2);
    check(ser_valid == 0, "R1 no capture sel_lo_n=1", ser_valid, 0);
    pins(1, 1, 1, 0, 8'h00); cyc(SS + 1);
    check(bus_oe == 0, "R1 no drive sel_lo_n=1", bus_oe, 0);
    pins(0, 0, 0, 0, 8'h22); cyc(SS + 2);
    check(ser_valid == 0, "R1 no capture sel_hi=0", ser_valid, 0);
    check(bus_oe == 0, "R1 no drive sel_hi=0", bus_oe, 0);
    pins(1, 0, 1, 1, 8'h00); cyc(SS + 1);

    // R5: both strobes low
    pins(0, 1, 0, 0, 8'h5A); cyc(SS + 2);
    check(bus_oe == 0, "R5 read ignored", bus_oe, 0);
    check(ser_valid == 1 && ser_data == 8'h5A, "R5 write done", ser_data, 8'h5A);
    pins(0, 1, 1, 1, 8'h00); cyc(SS + 1);
    ser_ready = 1; cyc(2); ser_ready = 0;
    check(overrun == 1, "R6 still sticky", overrun, 1);

    // random traffic, compared every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      bit [3:0] r;
      r = 4'($urandom);
      pins(r[0] & r[1], !(r[0] & r[1] & r[2]) | r[3], $urandom_range(0, 3) != 0,
           $urandom_range(0, 2) != 0, 8'($urandom));
      ser_ready = $urandom_range(0, 3) == 0;
      cyc($urandom_range(1, 6));
    end

    // R6/R8: only reset clears overrun
    pins(1, 0, 1, 1, 8'h00);
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
    check(overrun == 0, "R8 overrun cleared by reset", overrun, 0);
    check(ser_valid == 0, "R8 valid cleared by reset", ser_valid, 0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule